// File: doc/BRIEF.md
# Down-Counting Edge-Aligned PWM Generator

This block produces an edge-aligned pulse-width-modulated output from a period counter that runs downward. On each frame start the counter loads the frame length minus one and steps down to zero. The output is active while the counter value is below the latched duty value. As a result the turn-on point moves with the duty setting and the turn-off point always falls at the frame boundary. An inversion input flips the output level, which turns the waveform into its mirror with a fixed rising edge and a moving falling edge.

A run input of 0 holds the generator idle with its output inactive. Raising run starts a frame on that same clock edge. Several copies fed with the same frame length stay locked to the clock offsets at which their run inputs were raised. This gives phase-shifted channels without any shared counter. The duty and frame length inputs are sampled only at frame starts, so a frame in progress is never cut short or stretched.

Top module: `pwm_saw_down`

## Requirements
- R1: While rst_n is 0 or run is 0, pwm_out sits at its inactive level: pwm_out equals invert. Driving run to 0 makes the output inactive after the next rising clock edge.
- R2: With run held at 1, frames start at the rising edge where run is first sampled high and then every frame_len clocks. frame_len must be at least 1.
- R3: Number frame cycles k = 0 to frame_len-1 from the frame start. Cycle k is active exactly when frame_len-1-k < duty. The active stretch therefore lies at the end of the frame and ends on the frame boundary.
- R4: A duty value written mid-frame has no effect until the next frame start.
- R5: A duty of 0 gives an output that is never active.
- R6: A duty equal to or greater than frame_len gives an output that is active in every cycle.
- R7: When invert is 1, pwm_out is the complement of the non-inverted waveform. Active means high when invert is 0 and low when invert is 1.
- R8: Two instances with equal frame_len and duty, released N clocks apart, produce identical outputs offset by exactly N clocks.
- R9: A frame_len value changed mid-frame takes effect only from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 0 holds the generator idle, 1 lets it run |
| frame_len | input | CNT_W | Frame length in clocks, sampled at each frame start |
| duty | input | CNT_W | Active cycles per frame, sampled at each frame start |
| invert | input | 1 | Output polarity select |
| pwm_out | output | 1 | PWM output |

## Verification
A counter that skips or repeats a value changes the frame length. That shows up within one frame as a shifted turn-on edge and a misplaced turn-off edge. A duty register that loads at the wrong time changes the active count of the frame in which the write happens, so the damage is visible before the next boundary. A wrong idle state shows at the first edge after release, because the output of the first frame then no longer starts from the full count. Comparing two staggered instances over more than two frames also exposes any drift in frame timing.

// File: rtl/pwm_saw_down.sv
module pwm_saw_down #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] frame_len,
  input  logic [CNT_W-1:0] duty,
  input  logic             invert,
  output logic             pwm_out
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] cnt, duty_q, frame_q;
  logic live;
  logic reload;
  logic on_raw;

  assign reload = !live || (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      duty_q  <= '0;
      frame_q <= '0;
      live    <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      live <= 1'b0;
    end else if (reload) begin
      cnt     <= frame_len - ONE;
      duty_q  <= duty;
      frame_q <= frame_len;
      live    <= 1'b1;
    end else begin
      cnt <= cnt - ONE;
    end
  end

  assign on_raw  = live && (cnt < duty_q);
  assign pwm_out = on_raw ^ invert;

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !live);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && live && cnt != '0) |=> (cnt == $past(cnt) - ONE));

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && frame_q != '0) |-> (cnt < frame_q));

  p_off_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $fell(on_raw)) |-> (cnt == frame_q - ONE));

  p_duty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && live && cnt != '0) |=> $stable(duty_q));

  p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && live && cnt != '0) |=> $stable(frame_q));
endmodule

// File: tb/pwm_saw_down_test.sv
module pwm_saw_down_test;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_a = 1'b0, run_b = 1'b0;
  logic [W-1:0] frame_len = 10'd8;
  logic [W-1:0] duty = 10'd3;
  logic invert = 1'b0;
  logic out_a, out_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_saw_down #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .run(run_a), .frame_len(frame_len),
    .duty(duty), .invert(invert), .pwm_out(out_a));

  pwm_saw_down #(.CNT_W(W)) uut_b (
    .clk(clk), .rst_n(rst_n), .run(run_b), .frame_len(frame_len),
    .duty(duty), .invert(invert), .pwm_out(out_b));

  task automatic check(input string req, input logic act, input logic exp, input int at);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at sample %0d: actual %b expected %b", req, at, act, exp);
    end
  endtask

  function automatic logic expect_on(int f, int d, int k, logic inv);
    return logic'((f - 1 - (k % f)) < d) ^ inv;
  endfunction

  task automatic stop_all();
    @(negedge clk);
    run_a = 1'b0;
    run_b = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    invert = 1'b0;
    check("R1 reset", out_a, 1'b0, 0);
    invert = 1'b1;
    #1 check("R1 reset inverted", out_a, 1'b1, 0);
    invert = 1'b0;
  endtask

  task automatic t_frames(input int f, input int d, input logic inv, input int nfr, input string req);
    stop_all();
    frame_len = W'(f);
    duty = W'(d);
    invert = inv;
    run_a = 1'b1;
    for (int k = 0; k < f * nfr; k++) begin
      @(negedge clk);
      check(req, out_a, expect_on(f, d, k, inv), k);
    end
  endtask

  task automatic t_stop();
    t_frames(8, 8, 1'b0, 1, "R6 setup");
    run_a = 1'b0;
    @(negedge clk);
    check("R1 run low", out_a, 1'b0, 0);
    @(negedge clk);
    check("R1 run low held", out_a, 1'b0, 1);
  endtask

  task automatic t_duty_mid();
    stop_all();
    frame_len = 10'd10;
    duty = 10'd3;
    invert = 1'b0;
    run_a = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      check("R4 duty latched at frame start", out_a,
            expect_on(10, (k < 10) ? 3 : 7, k, 1'b0), k);
      if (k == 4) duty = 10'd7;
    end
  endtask

  task automatic t_frame_mid();
    logic exp;
    stop_all();
    frame_len = 10'd8;
    duty = 10'd2;
    invert = 1'b0;
    run_a = 1'b1;
    for (int k = 0; k < 8 + 15; k++) begin
      @(negedge clk);
      if (k < 8) exp = expect_on(8, 2, k, 1'b0);
      else exp = expect_on(5, 2, k - 8, 1'b0);
      check("R9 frame length latched at frame start", out_a, exp, k);
      if (k == 3) frame_len = 10'd5;
    end
  endtask

  task automatic t_phase();
    logic hist [0:1299];
    stop_all();
    frame_len = 10'd512;
    duty = 10'd200;
    invert = 1'b0;
    run_a = 1'b1;
    for (int k = 0; k < 1300; k++) begin
      if (k == 128) run_b = 1'b1;
      @(negedge clk);
      hist[k] = out_a;
      if (k == 0 || k == 311 || k == 312 || k == 511 || k == 512 || k == 824)
        check("R8 reference channel", out_a, expect_on(512, 200, k, 1'b0), k);
      if (k < 128)
        check("R8 staggered channel idle", out_b, 1'b0, k);
      else if (k % 37 == 0 || k == 128 + 311 || k == 128 + 312 || k == 128 + 511 || k == 128 + 512)
        check("R8 offset kept", out_b, hist[k - 128], k);
    end
  endtask

  initial begin
    #5;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_frames(8, 3, 1'b0, 3, "R2 R3 period and end-aligned pulse");
    t_frames(16, 11, 1'b0, 2, "R3 wider duty");
    t_frames(8, 0, 1'b0, 2, "R5 zero duty");
    t_frames(8, 8, 1'b0, 2, "R6 duty equals frame");
    t_frames(6, 900, 1'b0, 2, "R6 duty above frame");
    t_frames(8, 3, 1'b1, 2, "R7 inverted polarity");
    t_frames(1, 1, 1'b0, 3, "R2 single-cycle frame");
    t_stop();
    t_duty_mid();
    t_frame_mid();
    t_phase();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule